// File: doc/BRIEF.md
# Dual-Accumulator Arithmetic Unit with Chained Overflow Flags

This block is the arithmetic and logic core of a small fixed-point signal processor. It holds two 16-bit accumulators, each paired with its own six-bit flag set, and applies one of fifteen operations each clock. The operation combines the chosen accumulator with a second operand. That operand can be the data-RAM word at the current data pointer, the value on the internal bus, or one of the two halves of a signed 16x16 product. The product is recomputed from the K and L inputs on every clock, whatever operation is running. The RAM and the instruction sequencing sit outside the block. The word the RAM presents at the data pointer arrives on a plain input.

The flags support multi-step fixed-point arithmetic. A transient overflow flag reports the last operation alone. A sticky overflow flag collects overflows across a sequence, but a second overflow in the opposite direction cancels it. A second sign flag keeps the sign seen before the first unresolved overflow, so that later code can saturate in the right direction. The carry-using operations take the carry of the other accumulator, which lets two accumulators be chained into a 32-bit value.

Top module: `dacc_alu`

## Requirements
- R1: The second operand P is chosen by `p_sel`: 0 takes `ram_word`, 1 takes `bus_val`, 2 takes the registered `mul_hi`, and 3 takes the registered `mul_lo`.
- R2: Codes 1 (OR), 2 (AND), 3 (XOR) and 0xA (NOT of the accumulator) form a logic result, and they clear carry and both overflow flags.
- R3: Codes 4 (acc−P) and 5 (acc+P) subtract and add. Code 6 computes acc−P−c' and code 7 computes acc+P+c', where c' is the carry flag of the accumulator that is not selected.
- R4: Code 8 decrements and code 9 increments the accumulator, and P counts as 1 in the flag equations.
- R5: Code 0xB is an arithmetic right shift by one, with carry taken from old bit 0. Code 0xC shifts left by one, fills bit 0 with c', and takes carry from old bit 15. Both clear the two overflow flags.
- R6: Code 0xD shifts left by 2 and code 0xE shifts left by 4, both filling with ones. Code 0xF swaps the bytes. All three clear carry and both overflow flags.
- R7: The flag ports pack as bit5 ov1, bit4 ov0, bit3 s1, bit2 s0, bit1 z, bit0 c. z is set when the result is 0, and s0 is result bit 15. s1 takes the new s0 only if ov1 was clear before the operation; otherwise s1 keeps its old value.
- R8: For codes 4 to 9, V=(acc^res)&(P^res) for add forms (odd codes) and V=(acc^res)&(P^acc) for subtract forms (even codes). ov0 is V[15], and carry is bit 15 of acc^P^res^V.
- R9: After an arithmetic operation, if ov0 is set and ov1 was already set, ov1 becomes (new s0 == s1). Otherwise ov1 becomes old ov1 OR ov0.
- R10: On each clock, with product = signed K × signed L, `mul_hi` is loaded with bits [30:15] of the product and `mul_lo` with the product shifted left by one, truncated to 16 bits.
- R11: The result and flags go only to the accumulator chosen by `acc_sel` (0 = A, 1 = B). Code 0 changes neither accumulator nor either flag set.
- R12: A synchronous high `rst` clears both accumulators, both flag sets and both product registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_op | input | 4 | Operation code |
| p_sel | input | 2 | Second-operand selector |
| acc_sel | input | 1 | Accumulator select (0 = A, 1 = B) |
| bus_val | input | 16 | Internal bus value |
| ram_word | input | 16 | RAM word at the data pointer |
| mul_k | input | 16 | Multiplier operand K |
| mul_l | input | 16 | Multiplier operand L |
| acc_a | output | 16 | Accumulator A |
| acc_b | output | 16 | Accumulator B |
| flags_a | output | 6 | Flags of A (R7 packing) |
| flags_b | output | 6 | Flags of B (R7 packing) |
| mul_hi | output | 16 | Product bits [30:15] |
| mul_lo | output | 16 | Product shifted left by one |

## Verification
The hardest case to reach is the sticky overflow being cancelled. It needs ov1 already set by an earlier overflow, then a second overflow whose new sign differs from the frozen s1, and the accumulator has no load path. The stimulus first ORs 0x7FFF from the bus into an accumulator. It then increments past the positive limit, which sets ov1 and freezes s1 at 1, and decrements back across the limit, which must clear ov1. A long run of pseudo-random operations follows, compared every clock against a behavioural model, so that chains of carry-using operations between A and B also occur.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    parameter int DW = 16;

    typedef enum logic [3:0] {
        OP_NOP  = 4'h0, OP_OR   = 4'h1, OP_AND  = 4'h2, OP_XOR  = 4'h3,
        OP_SUB  = 4'h4, OP_ADD  = 4'h5, OP_SBB  = 4'h6, OP_ADC  = 4'h7,
        OP_DEC  = 4'h8, OP_INC  = 4'h9, OP_NOT  = 4'hA, OP_ASR  = 4'hB,
        OP_SHL1 = 4'hC, OP_SHL2 = 4'hD, OP_SHL4 = 4'hE, OP_SWAP = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_RAM = 2'd0, SRC_BUS = 2'd1, SRC_MHI = 2'd2, SRC_MLO = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic ov1;
        logic ov0;
        logic s1;
        logic s0;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        flags_t        fl;
    } alu_out_t;

    function automatic logic is_arith(input logic [3:0] op);
        return (op >= 4'h4) && (op <= 4'h9);
    endfunction

    function automatic logic clears_all(input logic [3:0] op);
        return (op inside {4'h1, 4'h2, 4'h3, 4'hA, 4'hD, 4'hE, 4'hF});
    endfunction
endpackage

// File: rtl/dacc_operand_mux.sv
module dacc_operand_mux
    import dacc_pkg::*;
(
    input  logic [1:0]    sel,
    input  logic [DW-1:0] ram_word,
    input  logic [DW-1:0] bus_val,
    input  logic [DW-1:0] mul_hi,
    input  logic [DW-1:0] mul_lo,
    output logic [DW-1:0] p_out
);
    always_comb begin
        unique case (src_sel_e'(sel))
            SRC_RAM: p_out = ram_word;
            SRC_BUS: p_out = bus_val;
            SRC_MHI: p_out = mul_hi;
            default: p_out = mul_lo;
        endcase
    end
endmodule

// File: rtl/dacc_alu_core.sv
module dacc_alu_core
    import dacc_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] p_in,
    input  flags_t        fl_old,
    input  logic          other_c,
    output alu_out_t      out
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] p_eff;
    logic [DW-1:0] res;
    logic [DW-1:0] ovec;
    logic [DW-1:0] cin;
    flags_t        fl;

    assign cin = {{(DW-1){1'b0}}, other_c};

    always_comb begin
        p_eff = p_in;
        res   = '0;
        unique case (alu_op_e'(op))
            OP_OR:   res = acc | p_eff;
            OP_AND:  res = acc & p_eff;
            OP_XOR:  res = acc ^ p_eff;
            OP_SUB:  res = acc - p_eff;
            OP_ADD:  res = acc + p_eff;
            OP_SBB:  res = acc - p_eff - cin;
            OP_ADC:  res = acc + p_eff + cin;
            OP_DEC:  begin p_eff = {{(DW-1){1'b0}}, 1'b1}; res = acc - p_eff; end
            OP_INC:  begin p_eff = {{(DW-1){1'b0}}, 1'b1}; res = acc + p_eff; end
            OP_NOT:  res = ~acc;
            OP_ASR:  res = {acc[DW-1], acc[DW-1:1]};
            OP_SHL1: res = {acc[DW-2:0], other_c};
            OP_SHL2: res = {acc[DW-3:0], 2'b11};
            OP_SHL4: res = {acc[DW-5:0], 4'hF};
            OP_SWAP: res = {acc[HALF-1:0], acc[DW-1:HALF]};
            default: res = '0;
        endcase
    end

    assign ovec = (acc ^ res) & (p_eff ^ (op[0] ? res : acc));

    always_comb begin
        fl    = fl_old;
        fl.z  = (res == '0);
        fl.s0 = res[DW-1];
        if (!fl_old.ov1) fl.s1 = fl.s0;
        if (is_arith(op)) begin
            fl.ov0 = ovec[DW-1];
            if (fl.ov0 && fl_old.ov1) fl.ov1 = (fl.s0 == fl.s1);
            else                      fl.ov1 = fl_old.ov1 | fl.ov0;
            fl.c = (acc[DW-1] ^ p_eff[DW-1] ^ res[DW-1] ^ ovec[DW-1]);
        end else begin
            fl.ov0 = 1'b0;
            fl.ov1 = 1'b0;
            if (op == OP_ASR)       fl.c = acc[0];
            else if (op == OP_SHL1) fl.c = acc[DW-1];
            else                    fl.c = 1'b0;
        end
    end

    assign out.res = res;
    assign out.fl  = fl;
endmodule

// File: rtl/dacc_multiplier.sv
module dacc_multiplier
    import dacc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] k_in,
    input  logic [DW-1:0] l_in,
    output logic [DW-1:0] m_out,
    output logic [DW-1:0] n_out
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    assign prod = $signed(k_in) * $signed(l_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            m_out <= '0;
            n_out <= '0;
        end else begin
            m_out <= prod[PW-2:DW-1];
            n_out <= {prod[DW-2:0], 1'b0};
        end
    end

    // R10
    mul_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (k_in == '0) |=> (m_out == '0 && n_out == '0));
endmodule

// File: rtl/dacc_alu.sv
module dacc_alu
    import dacc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    alu_op,
    input  logic [1:0]    p_sel,
    input  logic          acc_sel,
    input  logic [15:0]   bus_val,
    input  logic [15:0]   ram_word,
    input  logic [15:0]   mul_k,
    input  logic [15:0]   mul_l,
    output logic [15:0]   acc_a,
    output logic [15:0]   acc_b,
    output logic [5:0]    flags_a,
    output logic [5:0]    flags_b,
    output logic [15:0]   mul_hi,
    output logic [15:0]   mul_lo
);
    logic [DW-1:0] acc_r [2];
    flags_t        fl_r  [2];
    logic [DW-1:0] p_val;
    alu_out_t      alu_res;

    dacc_multiplier u_mul (
        .clk(clk), .rst(rst), .k_in(mul_k), .l_in(mul_l),
        .m_out(mul_hi), .n_out(mul_lo)
    );

    dacc_operand_mux u_mux (
        .sel(p_sel), .ram_word(ram_word), .bus_val(bus_val),
        .mul_hi(mul_hi), .mul_lo(mul_lo), .p_out(p_val)
    );

    dacc_alu_core u_core (
        .op(alu_op), .acc(acc_r[acc_sel]), .p_in(p_val),
        .fl_old(fl_r[acc_sel]), .other_c(fl_r[~acc_sel].c), .out(alu_res)
    );

    for (genvar g = 0; g < 2; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_r[g] <= '0;
                fl_r[g]  <= '0;
            end else if (alu_op != OP_NOP && acc_sel == 1'(g)) begin
                acc_r[g] <= alu_res.res;
                fl_r[g]  <= alu_res.fl;
            end
        end
    end

    assign acc_a   = acc_r[0];
    assign acc_b   = acc_r[1];
    assign flags_a = fl_r[0];
    assign flags_b = fl_r[1];

    // R11
    nop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_op == OP_NOP) |=> ($stable(acc_a) && $stable(acc_b)
                                && $stable(flags_a) && $stable(flags_b)));
    // R11
    other_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_sel == 1'b0) |=> ($stable(acc_b) && $stable(flags_b)));
    // R9
    sticky_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_a[5]) |-> flags_a[4]);
    // R7
    sign_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        flags_a[5] |=> $stable(flags_a[3]));
    // R2
    logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clears_all(alu_op) && acc_sel == 1'b1) |=> (flags_b[0] == 1'b0 && flags_b[4] == 1'b0 && flags_b[5] == 1'b0));
endmodule

// File: tb/test_dacc_alu.sv
module test_dacc_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  alu_op = '0;
    logic [1:0]  p_sel = '0;
    logic        acc_sel = 1'b0;
    logic [15:0] bus_val = '0, ram_word = '0, mul_k = '0, mul_l = '0;
    logic [15:0] acc_a, acc_b, mul_hi, mul_lo;
    logic [5:0]  flags_a, flags_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    logic [15:0] e_acc [2];
    logic        e_z [2], e_s0 [2], e_s1 [2], e_o0 [2], e_o1 [2], e_c [2];
    logic [15:0] e_mh, e_ml;

    always #5 clk = ~clk;

    dacc_alu i_dacc_alu (
        .clk(clk), .rst(rst), .alu_op(alu_op), .p_sel(p_sel), .acc_sel(acc_sel),
        .bus_val(bus_val), .ram_word(ram_word), .mul_k(mul_k), .mul_l(mul_l),
        .acc_a(acc_a), .acc_b(acc_b), .flags_a(flags_a), .flags_b(flags_b),
        .mul_hi(mul_hi), .mul_lo(mul_lo)
    );

    function automatic logic [5:0] pack(input int i);
        return {e_o1[i], e_o0[i], e_s1[i], e_s0[i], e_z[i], e_c[i]};
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "acc_a", acc_a, e_acc[0]);
        check(tag, "acc_b", acc_b, e_acc[1]);
        check(tag, "flags_a", {10'd0, flags_a}, {10'd0, pack(0)});
        check(tag, "flags_b", {10'd0, flags_b}, {10'd0, pack(1)});
        check("R10", "mul_hi", mul_hi, e_mh);
        check("R10", "mul_lo", mul_lo, e_ml);
    endtask

    task automatic model(input logic [3:0] op, input logic [1:0] ps, input logic sel);
        int s = sel;
        int o = sel ? 0 : 1;
        logic [15:0] a = e_acc[s];
        logic [15:0] p, r, v;
        logic oc = e_c[o];
        logic old1 = e_o1[s];
        case (ps)
            2'd0: p = ram_word;
            2'd1: p = bus_val;
            2'd2: p = e_mh;
            default: p = e_ml;
        endcase
        if (op == 4'h8 || op == 4'h9) p = 16'd1;
        case (op)
            4'h1: r = a | p;
            4'h2: r = a & p;
            4'h3: r = a ^ p;
            4'h4: r = a - p;
            4'h5: r = a + p;
            4'h6: r = a - p - 16'(oc);
            4'h7: r = a + p + 16'(oc);
            4'h8: r = a - 16'd1;
            4'h9: r = a + 16'd1;
            4'hA: r = ~a;
            4'hB: r = 16'($signed(a) >>> 1);
            4'hC: r = (a << 1) | 16'(oc);
            4'hD: r = (a << 2) | 16'h0003;
            4'hE: r = (a << 4) | 16'h000F;
            4'hF: r = {a[7:0], a[15:8]};
            default: r = 16'h0;
        endcase
        if (op != 4'h0) begin
            e_acc[s] = r;
            e_z[s]   = (r == 16'h0);
            e_s0[s]  = r[15];
            if (!old1) e_s1[s] = r[15];
            if (op >= 4'h4 && op <= 4'h9) begin
                v = op[0] ? ((a ^ r) & (p ^ r)) : ((a ^ r) & (p ^ a));
                e_o0[s] = v[15];
                if (e_o0[s] && old1) e_o1[s] = (e_s0[s] == e_s1[s]);
                else e_o1[s] = old1 | e_o0[s];
                e_c[s] = a[15] ^ p[15] ^ r[15] ^ v[15];
            end else begin
                e_o0[s] = 1'b0;
                e_o1[s] = 1'b0;
                e_c[s]  = (op == 4'hB) ? a[0] : (op == 4'hC) ? a[15] : 1'b0;
            end
        end
    endtask

    task automatic step(input string tag, input logic [3:0] op, input logic [1:0] ps, input logic sel,
                        input logic [15:0] bv, input logic [15:0] rw, input logic [15:0] k, input logic [15:0] l);
        longint prod;
        @(negedge clk);
        alu_op = op; p_sel = ps; acc_sel = sel; bus_val = bv; ram_word = rw; mul_k = k; mul_l = l;
        model(op, ps, sel);
        prod = longint'($signed(k)) * longint'($signed(l));
        e_mh = 16'(prod >>> 15);
        e_ml = 16'(prod << 1);
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            e_acc[i] = '0; e_z[i] = 0; e_s0[i] = 0; e_s1[i] = 0; e_o0[i] = 0; e_o1[i] = 0; e_c[i] = 0;
        end
        e_mh = '0; e_ml = '0;
        repeat (3) @(posedge clk);
        #1;
        compare_all("R12");
        @(negedge clk);
        rst = 1'b0;
        // load A via OR from bus
        step("R1", 4'h1, 2'd1, 1'b0, 16'h7FFF, 16'h0, 16'h0, 16'h0);
        // overflow through increment sets ov1, freezes s1
        step("R4", 4'h9, 2'd1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
        // second overflow back must cancel ov1
        step("R9", 4'h8, 2'd1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
        // nop keeps everything
        step("R11", 4'h0, 2'd1, 1'b0, 16'hFFFF, 16'h0, 16'h4000, 16'h4000);
        // product halves as operands
        step("R1", 4'h5, 2'd2, 1'b1, 16'h0, 16'h0, 16'hC000, 16'h1234);
        step("R1", 4'h3, 2'd3, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0);
        // RAM operand and subtraction producing carry
        step("R8", 4'h4, 2'd0, 1'b0, 16'h0, 16'hFFFE, 16'h0, 16'h0);
        // carry chain: B uses A carry
        step("R3", 4'h7, 2'd0, 1'b1, 16'h0, 16'h0001, 16'h0, 16'h0);
        step("R3", 4'h6, 2'd1, 1'b1, 16'h8000, 16'h0, 16'h0, 16'h0);
        // shifts and swaps
        step("R5", 4'hB, 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
        step("R5", 4'hC, 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
        step("R6", 4'hD, 2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0);
        step("R6", 4'hE, 2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0);
        step("R6", 4'hF, 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
        step("R2", 4'hA, 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
        step("R2", 4'h2, 2'd1, 1'b0, 16'h00F0, 16'h0, 16'h0, 16'h0);
        // zero result and sign flags
        step("R7", 4'h3, 2'd1, 1'b0, acc_a, 16'h0, 16'h0, 16'h0);
        // pseudo-random run
        for (int n = 0; n < 3000; n++) begin
            step("R8", 4'($urandom), 2'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                 16'($urandom), 16'($urandom));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule